// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

This block computes CRC checksums for software or a small controller. It has four 32-bit registers behind a simple register port made of a valid strobe, a write flag, an address and write/read data. One register holds the mode. It chooses one of three generator polynomials: a 16-bit one usually called CRC-CCITT, the 16-bit CRC-16, or CRC-32. The mode register also holds two conditioning options for the data coming in and two for the checksum being read out.

To use the block, software first sets the mode. It then writes a starting value to the seed register, which restarts the calculation at once. Each write to the data register then folds one 32-bit word into the running checksum in a single clock. The checksum register always returns the running value after the selected read-side conditioning. The stored value itself is never altered by reads, so the options can be changed between reads.

Top module: `crc_engine`

## Requirements
- R1: After synchronous reset the mode register reads 0, and both the seed register and the checksum register read 0x0000FFFF.
- R2: Mode bits 1:0 select the polynomial. 00 selects CRC-CCITT (0x1021, 16 bits). 01 selects CRC-16 (0x8005, 16 bits). 10 or 11 selects CRC-32 (0x04C11DB7, 32 bits). In the 16-bit modes only the low 16 bits of the sum take part and are returned, and bits 31:16 of the checksum read as zero.
- R3: A data write folds all 32 bits into the sum in one clock. Bytes are taken from the most significant byte down, and bits within each byte from the MSB down, with a non-reflected shift-left update. The new sum can be read in the cycle after the write edge.
- R4: When mode bit 2 is set, the bits of each byte of the data word are reversed before the update.
- R5: When mode bit 3 is set, the data word is complemented (ones' complement) before the update. If bit 2 is also set, this is applied after the reversal.
- R6: When mode bit 4 is set, a checksum read returns the active-width sum in reversed bit order: all 32 bits for CRC-32, or the low 16 bits for the 16-bit modes.
- R7: When mode bit 5 is set, a checksum read returns the ones' complement of the active-width sum. Bits above the active width stay zero.
- R8: The mode register stores bits 5:0 of a write, and bits 31:6 always read as zero.
- R9: A seed write loads the full 32-bit value into the sum on the next edge, replacing whatever was accumulated. The seed register reads back the last value written.
- R10: Writes to the checksum register leave the sum unchanged, and reads of the data register return zero.
- R11: Byte address bits 3:2 select the register: 0x0 mode, 0x4 seed, 0x8 checksum, 0xC data. Reads are combinational while valid is high, and read data is zero when valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address, bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
Seeding with zero and feeding the word 0x00000001 must produce each bare polynomial value. A design with a wrong tap, a wrong width select, or 11 decoded as anything other than CRC-32 returns some other constant. A word with only bit 24 set exposes byte ordering: a design that shifts the least significant byte first, or that reverses the whole word instead of each byte, gives a different sum. Seeding with all ones in a 16-bit mode catches leakage of the upper half into the read path. The output options are checked with small seeds whose reversed and complemented images are known, so a reversal over the wrong width shows up as a shifted value.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int LANES    = WORD_W / BYTE_W;
    localparam int NARROW_W = 16;
    localparam int MODE_W   = 6;

    localparam logic [WORD_W-1:0] SUM_RESET  = 32'h0000_FFFF;
    localparam logic [WORD_W-1:0] POLY_CCITT = 32'h0000_1021;
    localparam logic [WORD_W-1:0] POLY_C16   = 32'h0000_8005;
    localparam logic [WORD_W-1:0] POLY_C32   = 32'h04C1_1DB7;

    typedef enum logic [1:0] {
        SEL_CCITT = 2'b00,
        SEL_C16   = 2'b01,
        SEL_C32A  = 2'b10,
        SEL_C32B  = 2'b11
    } poly_sel_e;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_SEED = 2'd1,
        REG_SUM  = 2'd2,
        REG_DATA = 2'd3
    } reg_sel_e;

    // Packed field order matches mode register bits 5..0
    typedef struct packed {
        logic      out_cpl;  // bit 5
        logic      out_rev;  // bit 4
        logic      in_cpl;   // bit 3
        logic      in_rev;   // bit 2
        poly_sel_e sel;      // bits 1:0
    } mode_t;

    typedef struct packed {
        logic              wide;
        logic [WORD_W-1:0] taps;
    } poly_cfg_t;

    function automatic poly_cfg_t decode_poly(input poly_sel_e s);
        poly_cfg_t c;
        unique case (s)
            SEL_CCITT: begin c.wide = 1'b0; c.taps = POLY_CCITT; end
            SEL_C16:   begin c.wide = 1'b0; c.taps = POLY_C16;   end
            default:   begin c.wide = 1'b1; c.taps = POLY_C32;   end
        endcase
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] flip_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] width_mask(input logic wide);
        return wide ? {WORD_W{1'b1}} : {{(WORD_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endfunction

endpackage

// File: rtl/crc_in_cond.sv
module crc_in_cond
    import crc_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  logic              rev_en,
    input  logic              cpl_en,
    output logic [WORD_W-1:0] cooked
);
    logic [WORD_W-1:0] flipped;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_in;
        assign lane_in = raw[g*BYTE_W +: BYTE_W];
        assign flipped[g*BYTE_W +: BYTE_W] = rev_en ? flip_byte(lane_in) : lane_in;
    end

    assign cooked = cpl_en ? ~flipped : flipped;
endmodule

// File: rtl/crc_core.sv
module crc_core
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load,
    input  logic [WORD_W-1:0] seed_val,
    input  logic              data_load,
    input  logic [WORD_W-1:0] data_word,
    input  poly_cfg_t         cfg,
    output logic [WORD_W-1:0] sum_q
);
    logic [WORD_W-1:0] next_sum;

    // Unrolled 32-step serial update, MSB of the word first
    always_comb begin
        logic [WORD_W-1:0] c;
        logic              fb;
        c = sum_q;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (cfg.wide) begin
                fb = c[WORD_W-1] ^ data_word[i];
                c  = {c[WORD_W-2:0], 1'b0} ^ (fb ? cfg.taps : '0);
            end else begin
                fb = c[NARROW_W-1] ^ data_word[i];
                c  = {{(WORD_W-NARROW_W){1'b0}},
                      c[NARROW_W-2:0], 1'b0} ^ (fb ? cfg.taps : '0);
            end
        end
        next_sum = c;
    end

    always_ff @(posedge clk) begin
        if (rst)            sum_q <= SUM_RESET;
        else if (seed_load) sum_q <= seed_val;
        else if (data_load) sum_q <= next_sum;
    end

    // R9
    seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> sum_q == $past(seed_val));

    // R2
    narrow_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (data_load && !seed_load && !cfg.wide) |=> sum_q[WORD_W-1:NARROW_W] == '0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!data_load && !seed_load) |=> $stable(sum_q));
endmodule

// File: rtl/crc_out_cond.sv
module crc_out_cond
    import crc_pkg::*;
(
    input  logic [WORD_W-1:0] sum,
    input  logic              wide,
    input  logic              rev_en,
    input  logic              cpl_en,
    output logic [WORD_W-1:0] result
);
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] active;
    logic [WORD_W-1:0] ordered;

    assign mask   = width_mask(wide);
    assign active = sum & mask;

    always_comb begin
        if (!rev_en)   ordered = active;
        else if (wide) ordered = flip_word(active);
        else           ordered = flip_word(active) >> (WORD_W - NARROW_W);
    end

    assign result = cpl_en ? (~ordered & mask) : ordered;
endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    mode_t             mode_q;
    logic [WORD_W-1:0] seed_q;
    logic [WORD_W-1:0] sum_q;
    logic [WORD_W-1:0] data_cooked;
    logic [WORD_W-1:0] sum_view;
    poly_cfg_t         cfg;
    reg_sel_e          sel;
    logic              wr_mode, wr_seed, wr_data, rd_en;

    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign rd_en   = bus_valid && !bus_write;
    assign wr_mode = bus_valid && bus_write && sel == REG_MODE;
    assign wr_seed = bus_valid && bus_write && sel == REG_SEED;
    assign wr_data = bus_valid && bus_write && sel == REG_DATA;
    assign cfg     = decode_poly(mode_q.sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            seed_q <= SUM_RESET;
        end else begin
            if (wr_mode) mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
            if (wr_seed) seed_q <= bus_wdata;
        end
    end

    crc_in_cond i_in_cond (
        .raw    (bus_wdata),
        .rev_en (mode_q.in_rev),
        .cpl_en (mode_q.in_cpl),
        .cooked (data_cooked)
    );

    crc_core i_core (
        .clk       (clk),
        .rst       (rst),
        .seed_load (wr_seed),
        .seed_val  (bus_wdata),
        .data_load (wr_data),
        .data_word (data_cooked),
        .cfg       (cfg),
        .sum_q     (sum_q)
    );

    crc_out_cond i_out_cond (
        .sum    (sum_q),
        .wide   (cfg.wide),
        .rev_en (mode_q.out_rev),
        .cpl_en (mode_q.out_cpl),
        .result (sum_view)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (sel)
                REG_MODE: bus_rdata = {{(WORD_W-MODE_W){1'b0}}, mode_q};
                REG_SEED: bus_rdata = seed_q;
                REG_SUM:  bus_rdata = sum_view;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R10
    sum_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && sel == REG_SUM) |=> $stable(sum_q));

    // R10
    data_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == REG_DATA) |-> bus_rdata == '0);

    // R8
    mode_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == REG_MODE) |-> bus_rdata[WORD_W-1:MODE_W] == '0);
endmodule

// File: tb/test_crc_engine.sv
module test_crc_engine;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_MODE = 4'h0, A_SEED = 4'h4, A_SUM = 4'h8, A_DATA = 4'hC;

    logic        clk = 0, rst = 1;
    logic        bus_valid = 0, bus_write = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    int checks = 0, fails = 0;
    logic done = 0;

    crc_engine i_crc_engine (.clk, .rst, .bus_valid, .bus_write, .bus_addr, .bus_wdata, .bus_rdata);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model built from R2..R7
    logic [31:0] m_sum;
    logic [5:0]  m_mode;

    function automatic logic [31:0] ref_step(logic [31:0] s, logic [31:0] w, logic [5:0] md);
        logic [31:0] d, p;
        logic wide, fb;
        d = w;
        if (md[2]) for (int b = 0; b < 4; b++)
            for (int k = 0; k < 8; k++) d[b*8+k] = w[b*8+7-k];
        if (md[3]) d = ~d;
        wide = md[1];
        p = md[1] ? 32'h04C11DB7 : (md[0] ? 32'h8005 : 32'h1021);
        for (int i = 31; i >= 0; i--) begin
            if (wide) begin fb = s[31] ^ d[i]; s = (s << 1) ^ (fb ? p : 0); end
            else begin fb = s[15] ^ d[i]; s = {16'h0, s[14:0], 1'b0} ^ (fb ? p : 0); end
        end
        return s;
    endfunction

    function automatic logic [31:0] ref_view(logic [31:0] s, logic [5:0] md);
        logic [31:0] r, m;
        m = md[1] ? 32'hFFFFFFFF : 32'h0000FFFF;
        s = s & m;
        r = s;
        if (md[4]) begin
            r = 0;
            for (int i = 0; i < 32; i++) r[i] = s[31-i];
            if (!md[1]) r = r >> 16;
        end
        if (md[5]) r = ~r & m;
        return r;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        if (a == A_MODE) m_mode = d[5:0];
        if (a == A_SEED) m_sum = d;
        if (a == A_DATA) m_sum = ref_step(m_sum, d, m_mode);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        logic [31:0] got;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1 got = bus_rdata;
        bus_valid = 0;
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, got, exp);
        end
    endtask

    task automatic t_reset;
        rd_chk(A_MODE, 32'h0, "R1");
        rd_chk(A_SEED, 32'h0000FFFF, "R1");
        rd_chk(A_SUM, 32'h0000FFFF, "R1");
        rd_chk(A_DATA, 32'h0, "R10");
    endtask

    task automatic t_poly_basis;
        logic [31:0] exp [4] = '{32'h1021, 32'h8005, 32'h04C11DB7, 32'h04C11DB7};
        for (int s = 0; s < 4; s++) begin
            wr(A_MODE, s);
            wr(A_SEED, 0);
            wr(A_DATA, 1);
            rd_chk(A_SUM, exp[s], "R2");
        end
    endtask

    task automatic t_mode_readback;
        wr(A_MODE, 32'hFFFF_FFFF);
        rd_chk(A_MODE, 32'h3F, "R8");
        wr(A_MODE, 32'hA5A5_A5C4);
        rd_chk(A_MODE, 32'h04, "R8");
    endtask

    task automatic t_stream;
        logic [31:0] words [3] = '{32'h3132_3334, 32'hDEAD_BEEF, 32'h0000_0000};
        for (int s = 0; s < 3; s++) begin
            wr(A_MODE, s);
            wr(A_SEED, 32'hFFFF_FFFF);
            foreach (words[i]) wr(A_DATA, words[i]);
            rd_chk(A_SUM, ref_view(m_sum, m_mode), "R3");
        end
        // byte order: MSB byte first
        wr(A_MODE, 0); wr(A_SEED, 0); wr(A_DATA, 32'h0100_0000);
        rd_chk(A_SUM, ref_step(0, 32'h0100_0000, 0), "R3");
    endtask

    task automatic t_in_opts;
        logic [31:0] e;
        wr(A_MODE, 32'h6); wr(A_SEED, 0); wr(A_DATA, 32'h8000_0000);
        e = ref_step(0, 32'h0100_0000, 6'h2);
        rd_chk(A_SUM, e, "R4");
        wr(A_MODE, 32'h8); wr(A_SEED, 32'h1234); wr(A_DATA, 32'hFFFF_FFFE);
        e = ref_step(32'h1234, 32'h0000_0001, 6'h0);
        rd_chk(A_SUM, e, "R5");
        wr(A_MODE, 32'hE); wr(A_SEED, 32'h5555_AAAA); wr(A_DATA, 32'h0F1E_2D3C);
        rd_chk(A_SUM, ref_view(m_sum, m_mode), "R5");
    endtask

    task automatic t_out_opts;
        wr(A_MODE, 32'h10); wr(A_SEED, 32'h1);
        rd_chk(A_SUM, 32'h8000, "R6");
        wr(A_MODE, 32'h12);
        rd_chk(A_SUM, 32'h8000_0000, "R6");
        wr(A_MODE, 32'h21); wr(A_SEED, 32'h1234);
        rd_chk(A_SUM, 32'hEDCB, "R7");
        wr(A_MODE, 32'h22); wr(A_SEED, 32'h1234_5678);
        rd_chk(A_SUM, 32'hEDCB_A987, "R7");
    endtask

    task automatic t_seed_and_ignore;
        wr(A_MODE, 32'h2); wr(A_SEED, 32'hFFFF_FFFF); wr(A_DATA, 32'hCAFE_F00D);
        wr(A_SEED, 32'h0BAD_CAFE);
        rd_chk(A_SUM, 32'h0BAD_CAFE, "R9");
        rd_chk(A_SEED, 32'h0BAD_CAFE, "R9");
        wr(A_SUM, 32'h1111_1111);
        rd_chk(A_SUM, 32'h0BAD_CAFE, "R10");
        wr(A_MODE, 32'h1); wr(A_SEED, 32'hFFFF_FFFF);
        rd_chk(A_SUM, 32'h0000_FFFF, "R2");
        rd_chk(A_SUM, m_sum & 32'hFFFF, "R11");
    endtask

    initial begin
        m_sum = 32'h0000FFFF; m_mode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        t_reset;
        t_poly_basis;
        t_mode_readback;
        t_stream;
        t_in_opts;
        t_out_opts;
        t_seed_and_ignore;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule